// File: doc/BRIEF.md
# Register-List Stack Push/Pop Sequencer

This block moves a set of registers to or from a stack in memory. An 8-bit mask chooses the registers. When the block is started, it latches the mask, the direction, the transfer width, the bank choice and the starting stack pointer. It then moves one register per clock through a memory request port and a register file port. When the last transfer is done, it raises a one-cycle done pulse and presents the updated stack pointer.

A push takes the highest set mask bit first. For each register it lowers the stack pointer by one 2-byte slot, then stores the register at the lowered address. A pop takes the lowest set mask bit first. For each register it reads the slot at the current pointer into the register, then raises the pointer by one slot. Pushing a set of registers and then popping them with the same mask restores them in their original order.

Both the memory and the register file answer combinationally in the cycle of the request. Opcode decoding and the storage arrays are outside the block.

Top module: `rls_stack_seq`

## Requirements
- R1: A pop visits set mask bits from bit 0 upward. For each one it reads memory at the current stack pointer (mem_en=1, mem_we=0), writes the read value to the register (rf_we=1), and then adds 2 to the stack pointer.
- R2: A push visits set mask bits from bit 7 downward. For each one it subtracts 2 from the stack pointer and writes the register to memory at the new pointer (mem_en=1, mem_we=1). The register file is only read during a push (rf_we=0).
- R3: Mask bit i addresses register i when bank_hi=0 and register 8+i when bank_hi=1. The register address is {bank_hi, i} on the 4-bit rf_addr.
- R4: In word mode (word_mode=1), all 16 bits move in both directions. A push sends the full register value as mem_wdata, and a pop sends the full memory word as rf_wdata.
- R5: In byte mode (word_mode=0), rf_byte=1 during each transfer and the pointer still steps by 2 per register. A pop writes {8'h00, memory bits 7:0} to the register, and only the low byte of the register is updated. A push stores {8'h00, register bits 7:0}.
- R6: Clear mask bits are skipped and take no cycle. An operation with n set bits makes exactly n transfers, in the n consecutive cycles after the start cycle, and moves the pointer by exactly 2n.
- R7: An empty mask makes no memory or register transfer. Done is raised in the first cycle after the start, and sp_out equals sp_in.
- R8: A start that arrives while an operation is in progress, including its done cycle, is ignored. It does not change the running sequence and it does not queue a second operation.
- R9: Done is high for exactly one cycle, the cycle after the last transfer. From that cycle on, sp_out holds the final pointer: sp_in − 2n after a push, sp_in + 2n after a pop.
- R10: While rst_n is low: done=0, mem_en=0, mem_we=0, rf_we=0, rf_byte=0 and sp_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| dir_push | input | 1 | 1 = push, 0 = pop |
| word_mode | input | 1 | 1 = 16-bit transfers, 0 = byte transfers |
| bank_hi | input | 1 | 0 = registers 0–7, 1 = registers 8–15 |
| reg_mask | input | 8 | Registers to transfer |
| sp_in | input | 16 | Starting stack pointer |
| mem_en | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Memory write (push) |
| mem_addr | output | 16 | Memory byte address of the slot |
| mem_wdata | output | 16 | Data to store |
| mem_rdata | input | 16 | Read data, valid in the request cycle |
| rf_addr | output | 4 | Register file address |
| rf_we | output | 1 | Register write (pop) |
| rf_byte | output | 1 | Transfer is byte-wide; only low byte written |
| rf_wdata | output | 16 | Data to write into the register |
| rf_rdata | input | 16 | Register read data, valid in the same cycle |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Final stack pointer |

## Verification
The start edge is counted as cycle 0. For a mask with n set bits, transfer k is on the ports in cycle k, done and the final pointer appear in cycle n+1, and cycle n+2 must be idle. An empty mask therefore shows done in cycle 1. Each scenario task drives its inputs on the falling edge and samples on every later falling edge. At each sample it compares the address, register index, write strobes and data with a sequence the bench builds from the mask rules. After cycle n+2 it checks the bench's memory and register models against the values the mask rules predict. The ignored-start case raises a second start in the middle of a run and another in the done cycle, then checks that the sequence is unchanged and that cycle n+2 stays idle.

// File: rtl/rls_pkg.sv
// Shared types for the register-list stack sequencer.
package rls_pkg;
    // Control states: idle, stepping through the mask, one-cycle completion.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rls_state_e;
endpackage

// File: rtl/rls_pick.sv
// Picks one set bit of a mask, either the lowest or the highest.
// Returns it as a one-hot vector and as a binary index.
// Assumes W is a power of two. With an empty mask the outputs are zero.
module rls_pick #(
    parameter int W  = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    input  logic          from_top,
    output logic [W-1:0]  onehot,
    output logic [IW-1:0] idx
);
    logic [W-1:0] rev_in;
    logic [W-1:0] search;
    logic [W-1:0] low1;
    logic [W-1:0] rev_out;

    // Mirror the mask so that "highest set" becomes "lowest set".
    for (genvar g = 0; g < W; g++) begin : g_rev_in
        assign rev_in[g] = mask[W-1-g];
    end

    assign search = from_top ? rev_in : mask;
    assign low1   = search & (~search + W'(1));

    // Mirror the isolated bit back into its real position.
    for (genvar g = 0; g < W; g++) begin : g_rev_out
        assign rev_out[g] = low1[W-1-g];
    end

    assign onehot = from_top ? rev_out : low1;

    // Binary encoding of the one-hot pick.
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rls_ctrl.sv
// Sequencer control. Accepts a start only when idle, steps once per
// cycle while register bits remain, then gives a single done cycle.
// Assumes the datapath reports whether the mask being loaded is non-empty
// and whether any bit remains after the current step.
module rls_ctrl
    import rls_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic load_any,
    input  logic rest_any,
    output logic load,
    output logic step,
    output logic done
);
    rls_state_e state_q, state_d;

    // Next-state and strobe decode.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        done    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = load_any ? ST_RUN : ST_DONE;
                end
            end
            ST_RUN: begin
                step = 1'b1;
                if (!rest_any) state_d = ST_DONE;
            end
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/rls_dpath.sv
// Sequencer datapath. Holds the latched operation, the pending mask and
// the running stack pointer. Forms the memory and register-file requests
// for the current step.
// Assumes that load and step are never high in the same cycle.
module rls_dpath #(
    parameter int MASK_W = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    localparam int IW     = $clog2(MASK_W),
    localparam int RF_AW  = IW + 1,
    localparam int SLOT_B = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              dir_push,
    input  logic              word_mode,
    input  logic              bank_hi,
    input  logic [MASK_W-1:0] reg_mask,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              load_any,
    output logic              rest_any,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [RF_AW-1:0]  rf_addr,
    output logic              rf_we,
    output logic              rf_byte,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [ADDR_W-1:0] sp_out
);
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(SLOT_B);

    logic [MASK_W-1:0] pend_q;
    logic [ADDR_W-1:0] sp_q;
    logic              push_q, word_q, bank_q;
    logic [MASK_W-1:0] pick_oh;
    logic [IW-1:0]     pick_idx;
    logic [ADDR_W-1:0] sp_dec, sp_inc;

    rls_pick #(.W(MASK_W)) pick_i (
        .mask     (pend_q),
        .from_top (push_q),
        .onehot   (pick_oh),
        .idx      (pick_idx)
    );

    assign load_any = |reg_mask;
    assign rest_any = |(pend_q & ~pick_oh);
    assign sp_dec   = sp_q - SLOT;
    assign sp_inc   = sp_q + SLOT;

    // Operation latch, pending-mask retirement and pointer stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            sp_q   <= '0;
            push_q <= 1'b0;
            word_q <= 1'b0;
            bank_q <= 1'b0;
        end else if (load) begin
            pend_q <= reg_mask;
            sp_q   <= sp_in;
            push_q <= dir_push;
            word_q <= word_mode;
            bank_q <= bank_hi;
        end else if (step) begin
            pend_q <= pend_q & ~pick_oh;
            sp_q   <= push_q ? sp_dec : sp_inc;
        end
    end

    // Request formation for the current step.
    always_comb begin
        mem_en    = step;
        mem_we    = step & push_q;
        rf_we     = step & ~push_q;
        rf_byte   = step & ~word_q;
        mem_addr  = push_q ? sp_dec : sp_q;
        rf_addr   = {bank_q, pick_idx};
        mem_wdata = word_q ? rf_rdata
                           : {{(DATA_W-BYTE_W){1'b0}}, rf_rdata[BYTE_W-1:0]};
        rf_wdata  = word_q ? mem_rdata
                           : {{(DATA_W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]};
    end

    assign sp_out = sp_q;
endmodule

// File: rtl/rls_stack_seq.sv
// Register-list stack push/pop sequencer, top level.
// Moves the registers chosen by a mask to or from a stack, one per cycle.
// A push takes the highest bit first and pre-decrements the pointer.
// A pop takes the lowest bit first and post-increments it.
// Assumes memory and register-file reads respond in the same cycle.
module rls_stack_seq #(
    parameter int MASK_W = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    localparam int RF_AW = $clog2(MASK_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_push,
    input  logic              word_mode,
    input  logic              bank_hi,
    input  logic [MASK_W-1:0] reg_mask,
    input  logic [ADDR_W-1:0] sp_in,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [RF_AW-1:0]  rf_addr,
    output logic              rf_we,
    output logic              rf_byte,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] sp_out
);
    logic load, step, load_any, rest_any;

    rls_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load_any (load_any),
        .rest_any (rest_any),
        .load     (load),
        .step     (step),
        .done     (done)
    );

    rls_dpath #(
        .MASK_W (MASK_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) dpath_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .dir_push  (dir_push),
        .word_mode (word_mode),
        .bank_hi   (bank_hi),
        .reg_mask  (reg_mask),
        .sp_in     (sp_in),
        .mem_rdata (mem_rdata),
        .rf_rdata  (rf_rdata),
        .load_any  (load_any),
        .rest_any  (rest_any),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rf_addr   (rf_addr),
        .rf_we     (rf_we),
        .rf_byte   (rf_byte),
        .rf_wdata  (rf_wdata),
        .sp_out    (sp_out)
    );
endmodule

// File: rtl/rls_stack_seq_chk.sv
// Protocol checker for the sequencer. It sees the top-level ports only.
module rls_stack_seq_chk #(
    parameter int MASK_W = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    localparam int RF_AW = $clog2(MASK_W) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [RF_AW-1:0]  rf_addr,
    input logic              rf_we,
    input logic              rf_byte,
    input logic [DATA_W-1:0] rf_wdata,
    input logic              done,
    input logic [ADDR_W-1:0] sp_out
);
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(DATA_W / 8);

    // R2: after a push write, the pointer equals the address just written.
    a_r2_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> sp_out == $past(mem_addr));

    // R1: after a pop read, the pointer is one slot above the address read.
    a_r1_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> sp_out == $past(mem_addr) + SLOT);

    // R1: a register write happens only together with a memory read.
    a_r1_rf_with_read: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (mem_en && !mem_we));

    // R5: byte transfers carry zero in the upper byte.
    a_r5_byte_zero_hi: assert property (@(posedge clk) disable iff (!rst_n)
        rf_byte |-> (rf_wdata[DATA_W-1:BYTE_W] == '0 && mem_wdata[DATA_W-1:BYTE_W] == '0));

    // R9: done lasts a single cycle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: no transfer takes place in the done cycle.
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_en);

    // R3: the bank bit stays fixed over back-to-back transfers.
    a_r3_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && $past(mem_en)) |-> $stable(rf_addr[RF_AW-1]));

    // R6: the pointer does not move outside of transfer cycles, except on a new load.
    a_r6_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done) |=> $stable(sp_out));
endmodule

bind rls_stack_seq rls_stack_seq_chk #(
    .MASK_W (MASK_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rf_addr   (rf_addr),
    .rf_we     (rf_we),
    .rf_byte   (rf_byte),
    .rf_wdata  (rf_wdata),
    .done      (done),
    .sp_out    (sp_out)
);

// File: tb/rls_stack_seq_tb_top.sv
// Directed bench for the register-list stack sequencer.
module rls_stack_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_push = 1'b0;
    logic        word_mode = 1'b0;
    logic        bank_hi = 1'b0;
    logic [7:0]  reg_mask = 8'h00;
    logic [15:0] sp_in = 16'h0000;
    logic        mem_en, mem_we, rf_we, rf_byte, done;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, rf_wdata, rf_rdata, sp_out;
    logic [3:0]  rf_addr;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [15:0] mem_m [0:255];
    logic [15:0] rf_m  [0:15];

    always #10 clk = ~clk;

    // Memory and register file models: combinational read, write on the rising edge.
    assign mem_rdata = mem_m[mem_addr[8:1]];
    assign rf_rdata  = rf_m[rf_addr];

    always @(posedge clk) begin
        if (mem_en && mem_we) mem_m[mem_addr[8:1]] <= mem_wdata;
        if (rf_we) begin
            if (rf_byte) rf_m[rf_addr][7:0] <= rf_wdata[7:0];
            else         rf_m[rf_addr]      <= rf_wdata;
        end
    end

    rls_stack_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_push(dir_push),
        .word_mode(word_mode), .bank_hi(bank_hi), .reg_mask(reg_mask),
        .sp_in(sp_in), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_addr(rf_addr),
        .rf_we(rf_we), .rf_byte(rf_byte), .rf_wdata(rf_wdata),
        .rf_rdata(rf_rdata), .done(done), .sp_out(sp_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // One operation. extra_at > 0 raises a second start at that cycle.
    task automatic run_op(input bit push, input bit word, input bit bank,
                          input logic [7:0] mask, input logic [15:0] sp,
                          input int extra_at);
        logic [15:0] e_addr [0:7];
        logic [3:0]  e_reg  [0:7];
        logic [15:0] e_val  [0:7];
        logic [15:0] cur;
        int n = 0;
        cur = sp;
        // Expected sequence from the ordering and pointer rules (R1, R2, R3, R5).
        for (int k = 0; k < 8; k++) begin
            int b;
            b = push ? 7 - k : k;
            if (mask[b]) begin
                e_reg[n] = {bank, 3'(b)};
                if (push) begin
                    cur = cur - 16'd2;
                    e_addr[n] = cur;
                    e_val[n] = word ? rf_m[e_reg[n]] : {8'h00, rf_m[e_reg[n]][7:0]};
                end else begin
                    e_addr[n] = cur;
                    e_val[n] = word ? mem_m[cur[8:1]]
                                    : {rf_m[e_reg[n]][15:8], mem_m[cur[8:1]][7:0]};
                    cur = cur + 16'd2;
                end
                n++;
            end
        end
        @(negedge clk);
        start = 1'b1; dir_push = push; word_mode = word; bank_hi = bank;
        reg_mask = mask; sp_in = sp;
        for (int c = 1; c <= n + 2; c++) begin
            @(negedge clk);
            start = (c == extra_at);
            if (c == extra_at) begin
                dir_push = ~push; reg_mask = 8'hFF; sp_in = 16'h0020;
            end
            if (c <= n) begin
                check(mem_en == 1'b1, "R6", "transfer present", 32'(mem_en), 32'd1);
                check(mem_we == push, push ? "R2" : "R1", "mem_we", 32'(mem_we), 32'(push));
                check(rf_we == !push, push ? "R2" : "R1", "rf_we", 32'(rf_we), 32'(!push));
                check(mem_addr == e_addr[c-1], push ? "R2" : "R1", "mem_addr",
                      32'(mem_addr), 32'(e_addr[c-1]));
                check(rf_addr == e_reg[c-1], "R3", "rf_addr", 32'(rf_addr), 32'(e_reg[c-1]));
                check(rf_byte == !word, "R5", "rf_byte", 32'(rf_byte), 32'(!word));
                if (push)
                    check(mem_wdata == e_val[c-1], word ? "R4" : "R5", "mem_wdata",
                          32'(mem_wdata), 32'(e_val[c-1]));
                else
                    check(rf_wdata[7:0] == e_val[c-1][7:0] &&
                          (!word || rf_wdata == e_val[c-1]) &&
                          (word || rf_wdata[15:8] == 8'h00),
                          word ? "R4" : "R5", "rf_wdata", 32'(rf_wdata), 32'(e_val[c-1]));
                check(done == 1'b0, "R9", "done early", 32'(done), 32'd0);
            end else if (c == n + 1) begin
                check(done == 1'b1, n == 0 ? "R7" : "R9", "done", 32'(done), 32'd1);
                check(mem_en == 1'b0, n == 0 ? "R7" : "R9", "mem_en at done", 32'(mem_en), 32'd0);
                check(sp_out == cur, n == 0 ? "R7" : "R9", "sp_out", 32'(sp_out), 32'(cur));
            end else begin
                check(done == 1'b0, "R9", "done one cycle", 32'(done), 32'd0);
                check(mem_en == 1'b0, "R8", "no queued op", 32'(mem_en), 32'd0);
                check(sp_out == cur, "R9", "sp_out held", 32'(sp_out), 32'(cur));
            end
        end
        start = 1'b0;
        // Storage contents after the operation.
        for (int k = 0; k < n; k++) begin
            if (push)
                check(mem_m[e_addr[k][8:1]] == e_val[k], word ? "R4" : "R5", "stored slot",
                      32'(mem_m[e_addr[k][8:1]]), 32'(e_val[k]));
            else
                check(rf_m[e_reg[k]] == e_val[k], word ? "R4" : "R5", "loaded register",
                      32'(rf_m[e_reg[k]]), 32'(e_val[k]));
        end
    endtask

    task automatic t_reset();
        check(done == 1'b0 && mem_en == 1'b0 && mem_we == 1'b0 && rf_we == 1'b0 &&
              rf_byte == 1'b0, "R10", "strobes in reset",
              32'({done, mem_en, mem_we, rf_we, rf_byte}), 32'd0);
        check(sp_out == 16'h0000, "R10", "sp_out in reset", 32'(sp_out), 32'd0);
    endtask

    task automatic t_roundtrip();
        logic [15:0] orig [0:7];
        for (int i = 0; i < 8; i++) orig[i] = rf_m[i];
        run_op(1'b1, 1'b1, 1'b0, 8'hFF, 16'h0180, 0);
        run_op(1'b0, 1'b1, 1'b1, 8'hFF, 16'h0170, 0);
        for (int i = 0; i < 8; i++)
            check(rf_m[8+i] == orig[i], "R3", "push/pop round trip",
                  32'(rf_m[8+i]), 32'(orig[i]));
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = 16'h5A00 ^ 16'(i * 259);
        for (int i = 0; i < 16; i++)  rf_m[i]  = 16'hA000 + 16'(i * 273);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        run_op(1'b0, 1'b1, 1'b0, 8'hA5, 16'h0040, 0);   // R1 R4 pop word, low bank
        run_op(1'b1, 1'b1, 1'b1, 8'h81, 16'h0100, 0);   // R2 R3 push word, high bank
        run_op(1'b1, 1'b0, 1'b0, 8'h3C, 16'h00C0, 0);   // R5 push byte
        run_op(1'b0, 1'b0, 1'b1, 8'hFF, 16'h0060, 0);   // R5 pop byte, high bank
        run_op(1'b0, 1'b1, 1'b0, 8'h00, 16'h0123, 0);   // R7 empty mask
        run_op(1'b1, 1'b1, 1'b0, 8'h0F, 16'h01A0, 2);   // R8 start mid-run
        run_op(1'b0, 1'b1, 1'b1, 8'h12, 16'h0010, 3);   // R8 start in done cycle
        run_op(1'b1, 1'b1, 1'b0, 8'h01, 16'h0000, 0);   // R6 single bit, pointer wraps
        t_roundtrip();                                  // R3 R4 push then pop
        summary();
    end
endmodule